// File: doc/BRIEF.md
# Strobe-Qualified Chip-Select Decoder for a Split Code/Data Bus

This block drives the chip selects of an external program memory and a data RAM on a bus of the 8051 kind, where instruction fetches and data accesses share one address bus. They are told apart only by which strobe is low. The block has three strobe inputs, all active-low: one for program fetches, one for data reads and one for data writes. A select goes low only when both hold: the address falls inside a configured region, and the active strobe is allowed to reach that kind of memory. The program memory is split into `NUM_EPROM` independently placed blocks. The data RAM is a single region.

A mode input chooses between two layouts. In split layout, program memory serves fetches only and RAM serves data only. In shared layout, program memory also answers data reads, so tables and constants can live beside code. A control register adds two options. One lets fetches run from RAM, with RAM taking priority wherever it overlaps program memory. The other is an I/O enable that is passed straight to an output pin. A per-block qualifier can tie a program-memory block to fetches only or to data reads only. With it, a code block and a data block can share addresses. In shared layout, a flag reports any configuration in which one data read or one fetch could hit two regions.

Top module: `harvard_cs_decoder`

## Requirements
- R1: A region is hit when (address AND mask) equals base. After reset, every base is all ones and every mask is zero, so no select can go low until the regions are configured.
- R2: With `combined_i` = 0, only a fetch can select a program block, and a data read can select only the RAM.
- R3: With `combined_i` = 1, a program block whose range holds the address is selected by either a fetch or a data read.
- R4: A data write selects the RAM when it hits, in either layout, and never selects a program block.
- R5: All selects are active-low. All of them stay high when no strobe is low, and also when more than one strobe is low.
- R6: The control register bit 1 is the RAM-fetch enable. When it is 0, a fetch never selects the RAM. When it is 1, a fetch that hits the RAM selects only the RAM, even if a program block also matches.
- R7: At most one select is low at any time. Apart from the R6 case, the lowest-numbered hitting program block wins, then the RAM.
- R8: In the qualifier register, bit i enables the qualifier of program block i, and bit `NUM_EPROM`+i chooses its side (0 = fetches only, 1 = data reads only). A block whose qualifier is disabled answers both strobes that its layout allows.
- R9: `cfg_err_o` is 1 only with `combined_i` = 1 when one of two things is true: two non-empty program blocks overlap and no qualifier separates them, or the RAM overlaps a non-empty program block that data reads can reach. A region is empty when its base has a 1 outside its mask.
- R10: The control register resets to zero. Bit 0 is the I/O enable and drives `io_en_o`. Bits above 1 are not stored and always read back as zero.
- R11: Register index map: 0..N-1 hold the program-block bases, N..2N-1 their masks, 2N the RAM base, 2N+1 the RAM mask, 2N+2 the control register and 2N+3 the qualifiers. A write takes effect at the next clock edge. Reads are combinational, and an unused index reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Latched bus address |
| psen_n_i | input | 1 | Program fetch strobe, active-low |
| rd_n_i | input | 1 | Data read strobe, active-low |
| wr_n_i | input | 1 | Data write strobe, active-low |
| combined_i | input | 1 | 1 = shared layout, 0 = split layout |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_idx_i | input | CFG_IW | Configuration register index |
| cfg_wdata_i | input | ADDR_W | Configuration write data |
| cfg_rdata_o | output | ADDR_W | Configuration read data for `cfg_idx_i` |
| eprom_cs_n_o | output | NUM_EPROM | Program-block selects, active-low |
| sram_cs_n_o | output | 1 | RAM select, active-low |
| io_en_o | output | 1 | I/O enable from control bit 0 |
| cfg_err_o | output | 1 | Overlap error in shared layout |

## Verification
The selects are combinational, so a wrong comparison, a wrong strobe gate or a broken priority shows at the pins in the same cycle as the access that exposes it. A corrupted configuration register stays hidden until an address in the affected range is used with a suitable strobe. The register readback and the overlap flag show such damage one clock edge after the write that caused it. Random regions, strobes and layouts are checked against a model in the bench, alongside directed cases for RAM priority, qualifiers, overlap and reserved bits.

// File: rtl/hcs_pkg.sv
package hcs_pkg;
   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_CODE = 2'd1,
      ACC_DRD  = 2'd2,
      ACC_DWR  = 2'd3
   } acc_e;

   function automatic acc_e classify(input logic psen_n, input logic rd_n, input logic wr_n);
      case ({psen_n, rd_n, wr_n})
         3'b011:  return ACC_CODE;
         3'b101:  return ACC_DRD;
         3'b110:  return ACC_DWR;
         default: return ACC_NONE;
      endcase
   endfunction
endpackage

// File: rtl/hcs_region_match.sv
module hcs_region_match #(
   parameter int AW = 16
) (
   input  logic [AW-1:0] addr_i,
   input  logic [AW-1:0] base_i,
   input  logic [AW-1:0] mask_i,
   output logic          hit_o
);
   assign hit_o = ((addr_i & mask_i) == base_i);
endmodule

// File: rtl/hcs_cfg_regs.sv
module hcs_cfg_regs #(
   parameter int AW = 16,
   parameter int N  = 4,
   parameter int IW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_i,
   input  logic [IW-1:0] idx_i,
   input  logic [AW-1:0] wdata_i,
   output logic [AW-1:0] rdata_o,
   output logic [AW-1:0] ebase_o [N],
   output logic [AW-1:0] emask_o [N],
   output logic [AW-1:0] sbase_o,
   output logic [AW-1:0] smask_o,
   output logic          srcode_o,
   output logic          io_en_o,
   output logic [N-1:0]  qen_o,
   output logic [N-1:0]  qdat_o
);
   localparam int IDX_SBASE = 2 * N;
   localparam int IDX_SMASK = 2 * N + 1;
   localparam int IDX_CTRL  = 2 * N + 2;
   localparam int IDX_QUAL  = 2 * N + 3;

   logic [1:0] ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin
            ebase_o[i] <= '1;
            emask_o[i] <= '0;
         end
         sbase_o <= '1;
         smask_o <= '0;
         ctrl_q  <= '0;
         qen_o   <= '0;
         qdat_o  <= '0;
      end else if (we_i) begin
         for (int i = 0; i < N; i++) begin
            if (idx_i == IW'(i))     ebase_o[i] <= wdata_i;
            if (idx_i == IW'(N + i)) emask_o[i] <= wdata_i;
         end
         if (idx_i == IW'(IDX_SBASE)) sbase_o <= wdata_i;
         if (idx_i == IW'(IDX_SMASK)) smask_o <= wdata_i;
         if (idx_i == IW'(IDX_CTRL))  ctrl_q  <= wdata_i[1:0];
         if (idx_i == IW'(IDX_QUAL)) begin
            qen_o  <= wdata_i[N-1:0];
            qdat_o <= wdata_i[2*N-1:N];
         end
      end
   end

   assign srcode_o = ctrl_q[1];
   assign io_en_o  = ctrl_q[0];

   always_comb begin
      rdata_o = '0;
      for (int i = 0; i < N; i++) begin
         if (idx_i == IW'(i))     rdata_o = ebase_o[i];
         if (idx_i == IW'(N + i)) rdata_o = emask_o[i];
      end
      if (idx_i == IW'(IDX_SBASE)) rdata_o = sbase_o;
      if (idx_i == IW'(IDX_SMASK)) rdata_o = smask_o;
      if (idx_i == IW'(IDX_CTRL))  rdata_o = AW'(ctrl_q);
      if (idx_i == IW'(IDX_QUAL))  rdata_o = AW'({qdat_o, qen_o});
   end

   // R10: reserved control bits never read back as one
   p_ctrl_rsvd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_i == IW'(IDX_CTRL)) |-> (rdata_o[AW-1:2] == '0));

   // R11: a control write shows in the readback after the edge
   p_ctrl_write_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && idx_i == IW'(IDX_CTRL)) |=> (ctrl_q == $past(wdata_i[1:0])));
endmodule

// File: rtl/hcs_overlap_chk.sv
module hcs_overlap_chk #(
   parameter int AW = 16,
   parameter int N  = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          combined_i,
   input  logic [AW-1:0] ebase_i [N],
   input  logic [AW-1:0] emask_i [N],
   input  logic [AW-1:0] sbase_i,
   input  logic [AW-1:0] smask_i,
   input  logic [N-1:0]  qen_i,
   input  logic [N-1:0]  qdat_i,
   output logic          err_o
);
   function automatic logic regions_meet(input logic [AW-1:0] ba, input logic [AW-1:0] ma,
                                         input logic [AW-1:0] bb, input logic [AW-1:0] mb);
      return ((ba & ~ma) == '0) && ((bb & ~mb) == '0) && (((ba ^ bb) & ma & mb) == '0);
   endfunction

   logic [N*N-1:0] pair_clash;
   logic [N-1:0]   ram_clash;

   for (genvar i = 0; i < N; i++) begin : g_row
      for (genvar j = 0; j < N; j++) begin : g_col
         if (j > i) begin : g_pair
            assign pair_clash[i*N+j] = regions_meet(ebase_i[i], emask_i[i], ebase_i[j], emask_i[j])
                                       && !(qen_i[i] && qen_i[j] && (qdat_i[i] != qdat_i[j]));
         end else begin : g_none
            assign pair_clash[i*N+j] = 1'b0;
         end
      end
      assign ram_clash[i] = regions_meet(ebase_i[i], emask_i[i], sbase_i, smask_i)
                            && (!qen_i[i] || qdat_i[i]);
   end

   assign err_o = combined_i && ((|pair_clash) || (|ram_clash));

   // R9: the flag is reserved for the shared layout
   p_sep_no_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !combined_i |-> !err_o);
endmodule

// File: rtl/hcs_select.sv
module hcs_select
   import hcs_pkg::*;
#(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  acc_e         acc_i,
   input  logic [N-1:0] ehit_i,
   input  logic         shit_i,
   input  logic         combined_i,
   input  logic         srcode_i,
   input  logic [N-1:0] qen_i,
   input  logic [N-1:0] qdat_i,
   output logic [N-1:0] es_n_o,
   output logic         ss_n_o
);
   logic [N-1:0] cand;
   logic         s_cand;
   logic [N-1:0] pick;
   logic         pick_s;
   logic         found;

   for (genvar i = 0; i < N; i++) begin : g_cand
      assign cand[i] = ehit_i[i] &&
                       (((acc_i == ACC_CODE) && (!qen_i[i] || !qdat_i[i])) ||
                        ((acc_i == ACC_DRD) && combined_i && (!qen_i[i] || qdat_i[i])));
   end

   assign s_cand = shit_i && ((acc_i == ACC_DRD) || (acc_i == ACC_DWR) ||
                              ((acc_i == ACC_CODE) && srcode_i));

   always_comb begin
      pick   = '0;
      pick_s = 1'b0;
      found  = 1'b0;
      if ((acc_i == ACC_CODE) && srcode_i && s_cand) begin
         pick_s = 1'b1;
      end else begin
         for (int i = 0; i < N; i++) begin
            if (cand[i] && !found) begin
               pick[i] = 1'b1;
               found   = 1'b1;
            end
         end
         if (!found) pick_s = s_cand;
      end
   end

   assign es_n_o = ~pick;
   assign ss_n_o = ~pick_s;

   p_one_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({~es_n_o, ~ss_n_o}));
   p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_i == ACC_NONE) |-> ((&es_n_o) && ss_n_o));
   p_wr_no_eprom_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_i == ACC_DWR) |-> (&es_n_o));
   p_sep_rd_no_eprom_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!combined_i && acc_i == ACC_DRD) |-> (&es_n_o));
   p_srcode_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_i == ACC_CODE && srcode_i && shit_i) |-> (!ss_n_o && (&es_n_o)));
   p_no_ram_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_i == ACC_CODE && !srcode_i) |-> ss_n_o);
endmodule

// File: rtl/harvard_cs_decoder.sv
module harvard_cs_decoder
   import hcs_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int NUM_EPROM = 4,
   parameter int CFG_IW    = $clog2(2 * NUM_EPROM + 4)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    addr_i,
   input  logic                 psen_n_i,
   input  logic                 rd_n_i,
   input  logic                 wr_n_i,
   input  logic                 combined_i,
   input  logic                 cfg_we_i,
   input  logic [CFG_IW-1:0]    cfg_idx_i,
   input  logic [ADDR_W-1:0]    cfg_wdata_i,
   output logic [ADDR_W-1:0]    cfg_rdata_o,
   output logic [NUM_EPROM-1:0] eprom_cs_n_o,
   output logic                 sram_cs_n_o,
   output logic                 io_en_o,
   output logic                 cfg_err_o
);
   localparam int NREG = 2 * NUM_EPROM + 4;

   if (NUM_EPROM < 1 || NUM_EPROM > 8) begin : g_bad_n
      $error("NUM_EPROM must lie in 1..8");
   end
   if (ADDR_W < 2 * NUM_EPROM || ADDR_W < 8) begin : g_bad_aw
      $error("ADDR_W too narrow for the qualifier register");
   end
   if ((1 << CFG_IW) < NREG) begin : g_bad_iw
      $error("CFG_IW cannot index every register");
   end

   acc_e                  acc;
   logic [ADDR_W-1:0]     ebase [NUM_EPROM];
   logic [ADDR_W-1:0]     emask [NUM_EPROM];
   logic [ADDR_W-1:0]     sbase, smask;
   logic                  srcode;
   logic [NUM_EPROM-1:0]  qen, qdat, ehit;
   logic                  shit;

   assign acc = classify(psen_n_i, rd_n_i, wr_n_i);

   hcs_cfg_regs #(.AW(ADDR_W), .N(NUM_EPROM), .IW(CFG_IW)) u_regs (
      .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .idx_i(cfg_idx_i),
      .wdata_i(cfg_wdata_i), .rdata_o(cfg_rdata_o),
      .ebase_o(ebase), .emask_o(emask), .sbase_o(sbase), .smask_o(smask),
      .srcode_o(srcode), .io_en_o(io_en_o), .qen_o(qen), .qdat_o(qdat)
   );

   for (genvar i = 0; i < NUM_EPROM; i++) begin : g_emat
      hcs_region_match #(.AW(ADDR_W)) u_match (
         .addr_i(addr_i), .base_i(ebase[i]), .mask_i(emask[i]), .hit_o(ehit[i])
      );
   end

   hcs_region_match #(.AW(ADDR_W)) u_smatch (
      .addr_i(addr_i), .base_i(sbase), .mask_i(smask), .hit_o(shit)
   );

   hcs_overlap_chk #(.AW(ADDR_W), .N(NUM_EPROM)) u_ovl (
      .clk(clk), .rst_n(rst_n), .combined_i(combined_i),
      .ebase_i(ebase), .emask_i(emask), .sbase_i(sbase), .smask_i(smask),
      .qen_i(qen), .qdat_i(qdat), .err_o(cfg_err_o)
   );

   hcs_select #(.N(NUM_EPROM)) u_sel (
      .clk(clk), .rst_n(rst_n), .acc_i(acc), .ehit_i(ehit), .shit_i(shit),
      .combined_i(combined_i), .srcode_i(srcode), .qen_i(qen), .qdat_i(qdat),
      .es_n_o(eprom_cs_n_o), .ss_n_o(sram_cs_n_o)
   );

   // R1: a select only drops for an address inside a configured region
   p_hit_needed_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_cs_n_o) |-> ((addr_i & smask) == sbase));
endmodule

// File: tb/tb_harvard_cs_decoder.sv
module tb_harvard_cs_decoder;
   localparam int CLK_P = 10;
   localparam int AW = 16;
   localparam int N = 4;
   localparam int IW = 4;
   localparam int I_SB = 2 * N, I_SM = 2 * N + 1, I_CT = 2 * N + 2, I_QU = 2 * N + 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic psen_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, comb = 1'b0;
   logic we = 1'b0;
   logic [IW-1:0] idx = '0;
   logic [AW-1:0] wdata = '0, rdata;
   logic [N-1:0] es_n;
   logic ss_n, io_en, err;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   logic [AW-1:0] m_eb [N];
   logic [AW-1:0] m_em [N];
   logic [AW-1:0] m_sb, m_sm;
   logic [1:0] m_ct;
   logic [N-1:0] m_qe, m_qd;

   always #(CLK_P / 2) clk = ~clk;

   harvard_cs_decoder #(.ADDR_W(AW), .NUM_EPROM(N), .CFG_IW(IW)) dut (
      .clk(clk), .rst_n(rst_n), .addr_i(addr), .psen_n_i(psen_n), .rd_n_i(rd_n),
      .wr_n_i(wr_n), .combined_i(comb), .cfg_we_i(we), .cfg_idx_i(idx),
      .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .eprom_cs_n_o(es_n),
      .sram_cs_n_o(ss_n), .io_en_o(io_en), .cfg_err_o(err)
   );

   task automatic mirror_reset();
      for (int i = 0; i < N; i++) begin m_eb[i] = '1; m_em[i] = '0; end
      m_sb = '1; m_sm = '0; m_ct = '0; m_qe = '0; m_qd = '0;
   endtask

   task automatic wr_cfg(input int i, input logic [AW-1:0] d);
      @(negedge clk);
      we = 1'b1; idx = IW'(i); wdata = d;
      @(negedge clk);
      we = 1'b0;
      if (i < N) m_eb[i] = d;
      else if (i < 2 * N) m_em[i-N] = d;
      else if (i == I_SB) m_sb = d;
      else if (i == I_SM) m_sm = d;
      else if (i == I_CT) m_ct = d[1:0];
      else if (i == I_QU) begin m_qe = d[N-1:0]; m_qd = d[2*N-1:N]; end
   endtask

   function automatic logic [N:0] exp_sel(input logic [AW-1:0] a, input logic p,
                                          input logic r, input logic w, input logic c);
      logic [N:0] res;
      bit code, drd, dwr, sh;
      res = '1;
      code = !p && r && w; drd = p && !r && w; dwr = p && r && !w;
      if (!(code || drd || dwr)) return res;
      sh = ((a & m_sm) == m_sb);
      if (code && m_ct[1] && sh) begin res[0] = 1'b0; return res; end
      for (int i = 0; i < N; i++) begin
         if ((a & m_em[i]) == m_eb[i]) begin
            if ((code && !(m_qe[i] && m_qd[i])) ||
                (drd && c && !(m_qe[i] && !m_qd[i]))) begin
               res[i+1] = 1'b0; return res;
            end
         end
      end
      if (sh && (drd || dwr)) res[0] = 1'b0;
      return res;
   endfunction

   function automatic bit meet(input logic [AW-1:0] ba, input logic [AW-1:0] ma,
                               input logic [AW-1:0] bb, input logic [AW-1:0] mb);
      if ((ba & ~ma) != 0 || (bb & ~mb) != 0) return 1'b0;
      return ((ba & ma & mb) == (bb & ma & mb));
   endfunction

   function automatic bit exp_err(input logic c);
      bit e = 1'b0;
      if (!c) return 1'b0;
      for (int i = 0; i < N; i++) begin
         for (int j = i + 1; j < N; j++)
            if (meet(m_eb[i], m_em[i], m_eb[j], m_em[j]) &&
                !(m_qe[i] && m_qe[j] && m_qd[i] != m_qd[j])) e = 1'b1;
         if (meet(m_eb[i], m_em[i], m_sb, m_sm) && !(m_qe[i] && !m_qd[i])) e = 1'b1;
      end
      return e;
   endfunction

   task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic access(input string tag, input logic [AW-1:0] a, input logic p,
                         input logic r, input logic w, input logic c);
      @(negedge clk);
      addr = a; psen_n = p; rd_n = r; wr_n = w; comb = c;
      #(CLK_P / 5);
      chk(tag, AW'({es_n, ss_n}), AW'(exp_sel(a, p, r, w, c)));
   endtask

   task automatic chk_err(input string tag);
      #1;
      chk(tag, AW'(err), AW'(exp_err(comb)));
   endtask

   task automatic chk_rd(input string tag, input int i, input logic [AW-1:0] exp);
      @(negedge clk);
      idx = IW'(i);
      #1;
      chk(tag, rdata, exp);
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run hung, actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      mirror_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      access("R1 reset: fetch selects nothing", 16'h0000, 0, 1, 1, 0);
      access("R1 reset: read selects nothing", 16'hFFFF, 1, 0, 1, 1);
      chk_rd("R10 control resets to zero", I_CT, 16'h0000);
      chk("R10 io enable low after reset", AW'(io_en), 16'h0);
      chk_err("R9 no error after reset");

      // layout of regions
      wr_cfg(0, 16'h0000); wr_cfg(N + 0, 16'hC000);
      wr_cfg(1, 16'h4000); wr_cfg(N + 1, 16'hC000);
      wr_cfg(2, 16'h8000); wr_cfg(N + 2, 16'hE000);
      wr_cfg(3, 16'hA000); wr_cfg(N + 3, 16'hE000);
      wr_cfg(I_SB, 16'hC000); wr_cfg(I_SM, 16'hF000);
      chk_rd("R11 mask readback", N + 2, 16'hE000);

      // split layout
      access("R2 fetch selects block 0", 16'h1234, 0, 1, 1, 0);
      access("R2 read misses program block", 16'h1234, 1, 0, 1, 0);
      access("R2 read selects ram", 16'hC010, 1, 0, 1, 0);
      access("R6 fetch ignores ram when disabled", 16'hC010, 0, 1, 1, 0);
      access("R4 write selects ram", 16'hC010, 1, 1, 0, 0);
      access("R4 write never picks program block", 16'h1234, 1, 1, 0, 1);
      access("R5 no strobe", 16'hC010, 1, 1, 1, 0);
      access("R5 two strobes", 16'h1234, 0, 0, 1, 1);
      access("R5 three strobes", 16'hC010, 0, 0, 0, 1);

      // shared layout
      access("R3 read selects block 1", 16'h5000, 1, 0, 1, 1);
      access("R3 fetch selects block 2", 16'h9000, 0, 1, 1, 1);
      access("R3 read selects block 3", 16'hA800, 1, 0, 1, 1);
      chk_err("R9 disjoint layout is clean");

      // fetch from ram
      wr_cfg(I_CT, 16'hFFFE);
      chk_rd("R10 reserved bits read zero", I_CT, 16'h0002);
      chk("R10 io enable follows bit 0", AW'(io_en), 16'h0);
      access("R6 fetch selects ram when enabled", 16'hC010, 0, 1, 1, 0);
      wr_cfg(I_SB, 16'h0000);
      access("R6 ram wins overlapping fetch", 16'h0100, 0, 1, 1, 1);
      access("R7 read prefers block 0 over ram", 16'h0100, 1, 0, 1, 1);
      chk_err("R9 ram overlaps readable block");
      access("R9 split layout hides overlap", 16'h0100, 1, 0, 1, 0);
      chk_err("R9 split layout no flag");
      wr_cfg(I_SB, 16'hC000);
      wr_cfg(I_CT, 16'h0001);
      chk("R10 io enable set", AW'(io_en), 16'h1);

      // overlapping program blocks and qualifiers
      wr_cfg(1, 16'h0000); wr_cfg(N + 1, 16'h8000);
      access("R7 lowest block wins", 16'h0100, 0, 1, 1, 1);
      chk_err("R9 block overlap flagged");
      wr_cfg(I_QU, 16'h0023);
      chk_rd("R11 qualifier readback", I_QU, 16'h0023);
      access("R8 fetch to code-only block", 16'h0100, 0, 1, 1, 1);
      access("R8 read skips code-only block", 16'h0100, 1, 0, 1, 1);
      chk_err("R9 qualifiers separate blocks");
      access("R8 split read cannot reach data block", 16'h0100, 1, 0, 1, 0);
      for (int i = 2 * N + 4; i < 16; i++) chk_rd("R11 unused index reads zero", i, 16'h0000);

      // random mix
      void'($urandom(32'd1234));
      for (int it = 0; it < 400; it++) begin
         if ($urandom_range(0, 3) == 0) begin
            int r = $urandom_range(0, 2 * N + 3);
            logic [AW-1:0] m = 16'hFFFF << (16 - $urandom_range(1, 4));
            logic [AW-1:0] d = AW'($urandom);
            if ((r >= N && r < 2 * N) || r == I_SM) d = m;
            else if (r < N || r == I_SB) d = ($urandom_range(0, 7) == 0) ? d : (d & 16'hF000);
            wr_cfg(r, d);
            chk_rd("R11 random readback", r, (r == I_CT) ? {14'd0, d[1:0]} :
                   (r == I_QU) ? {8'd0, d[7:0]} : d);
         end
         begin
            logic [2:0] s = 3'($urandom);
            access("R7 random access", AW'($urandom), s[2], s[1], s[0], 1'($urandom));
            chk_err("R9 random flag");
         end
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule